// File: doc/BRIEF.md
# Flash Page Program Sequencer

This block gathers single-word program requests for one flash page into a staging buffer and, once software asks for the operation to begin, merges the staged words into a behavioural flash array. A page holds eight 32-bit words. While the program-enable level `pgm_i` is high, the first accepted write fixes the page for the whole sequence. Later writes to the same page fill further slots. A write aimed at a different page is dropped and flagged on `reject_o`.

A one-cycle `start_i` pulse closes the loading phase. The sequencer then stays busy for a fixed, configurable number of cycles and rejects every write in that time. At the end of the busy window it applies the programming rule to each staged word: a bit may only fall from 1 to 0. Words in a block that is locked, or in a block that the array does not implement, are left as they were. `done_o` then rises and stays high until software drops `pgm_i`. The array is cleared to all ones by reset and can be read at any time through a combinational read port.

Top module: `fpgm_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `reject_o` are low and every array word reads 32'hFFFF_FFFF.
- R2: A committed word becomes the old stored value ANDed with the staged data, so programming never turns a 0 into a 1.
- R3: The slot within a page is byte-address bits [4:2] and the page is bits [ADDR_W-1:5]. Bits [1:0] have no effect, so byte addresses 0x004 and 0x007 hit the same word.
- R4: Several slots of one page can be staged in one sequence. Only staged slots are committed, and a slot written twice commits its last value.
- R5: The first accepted write of a sequence latches the page. A later write to another page changes nothing and raises `reject_o` in the cycle after that write.
- R6: If `lock_i[b]` is 1 at commit, no word of block b changes. The block index is byte-address bits [ADDR_W-1:8], so one block is 256 bytes.
- R7: Block indices at or above IMPL_BLOCKS (default 3) are never written, whatever their lock bit, and read as 32'hFFFF_FFFF.
- R8: `busy_o` rises in the cycle after the start edge and stays high for exactly PGM_CYCLES cycles (default 5). The array is unchanged while busy, and the merged data and `done_o` both appear in the first cycle after `busy_o` falls.
- R9: A write while `busy_o` or `done_o` is high changes nothing and raises `reject_o` one cycle later.
- R10: `done_o` stays high while `pgm_i` is high and falls one cycle after `pgm_i` goes low. With `pgm_i` low in the idle state, writes and `start_i` have no effect and raise no `reject_o`.
- R11: If `start_i` and a same-page write come in the same loading cycle, the start wins: the program begins, and that write is dropped and flagged on `reject_o`.
- R12: Dropping `pgm_i` during loading discards the staged words and returns to idle, where a `start_i` pulse does not begin a program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pgm_i | input | 1 | Program-enable level for a sequence |
| start_i | input | 1 | One-cycle pulse that begins the program |
| wr_en_i | input | 1 | Staging write strobe |
| wr_addr_i | input | ADDR_W | Byte address of the staging write |
| wr_data_i | input | 32 | Data of the staging write |
| lock_i | input | 2**(ADDR_W-8) | Per-block program lock, 1 = locked |
| rd_addr_i | input | ADDR_W | Byte address of the array read |
| rd_data_o | output | 32 | Array word at `rd_addr_i` (combinational) |
| busy_o | output | 1 | Program in progress |
| done_o | output | 1 | Program finished, held until `pgm_i` drops |
| reject_o | output | 1 | Pulse: the write of the previous cycle was dropped |

## Verification
The start pulse and a staging write can arrive in the same loading cycle. In that case the block must both begin the program and refuse the write. The bench provokes this by driving `start_i` together with a write to an unused slot of the latched page. It then checks that `busy_o` and `reject_o` are both high one cycle later, and after completion it reads that slot back as erased. A second overlap is a write during the busy window: the checker requires `reject_o` to follow it, and the bench confirms that the array is untouched.

// File: rtl/fpgm_pkg.sv
package fpgm_pkg;

    localparam int WORD_W     = 32;
    localparam int PAGE_WORDS = 8;
    localparam int SLOT_W     = $clog2(PAGE_WORDS);
    localparam int BYTE_OFS_W = 2;
    localparam int PAGE_OFS_W = SLOT_W + BYTE_OFS_W;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t ERASED_WORD = '1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PGM,
        ST_DONE
    } fpgm_state_e;

    typedef struct packed {
        logic  [PAGE_WORDS-1:0] valid;
        word_t [PAGE_WORDS-1:0] data;
    } pbuf_t;

    // Programming only discharges cells: a bit can fall, never rise.
    function automatic word_t program_merge(input word_t cur, input word_t req);
        return cur & req;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input logic [PAGE_OFS_W-1:0] ofs);
        return ofs[PAGE_OFS_W-1:BYTE_OFS_W];
    endfunction

endpackage

// File: rtl/fpgm_ctrl.sv
module fpgm_ctrl
    import fpgm_pkg::*;
#(
    parameter int PGM_CYCLES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic pgm_i,
    input  logic start_i,
    input  logic wr_en_i,
    input  logic same_page_i,
    output logic take_first_o,
    output logic take_more_o,
    output logic commit_o,
    output logic busy_o,
    output logic done_o,
    output logic reject_o
);

    localparam int CNT_W = (PGM_CYCLES < 2) ? 1 : $clog2(PGM_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PGM_CYCLES - 1);

    fpgm_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             reject_q, reject_d;
    logic             launch;

    always_comb begin
        launch       = (state_q == ST_LOAD) && pgm_i && start_i;
        take_first_o = (state_q == ST_IDLE) && pgm_i && wr_en_i;
        take_more_o  = (state_q == ST_LOAD) && pgm_i && wr_en_i
                       && same_page_i && !start_i;
        commit_o     = (state_q == ST_PGM) && (cnt_q == '0);

        reject_d = 1'b0;
        if (wr_en_i) begin
            case (state_q)
                ST_PGM:  reject_d = 1'b1;
                ST_DONE: reject_d = pgm_i;
                ST_LOAD: reject_d = pgm_i && (!same_page_i || start_i);
                default: reject_d = 1'b0;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (take_first_o) state_d = ST_LOAD;
            ST_LOAD: begin
                if (!pgm_i)      state_d = ST_IDLE;
                else if (launch) state_d = ST_PGM;
            end
            ST_PGM:  if (commit_o) state_d = ST_DONE;
            ST_DONE: if (!pgm_i)   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            reject_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            reject_q <= reject_d;
            if (launch) begin
                cnt_q <= CNT_LOAD;
            end else if ((state_q == ST_PGM) && (cnt_q != '0)) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy_o   = (state_q == ST_PGM);
    assign done_o   = (state_q == ST_DONE);
    assign reject_o = reject_q;

endmodule

// File: rtl/fpgm_pagebuf.sv
module fpgm_pagebuf
    import fpgm_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_first_i,
    input  logic              take_more_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  word_t             wr_data_i,
    output logic              same_page_o,
    output logic [ADDR_W-PAGE_OFS_W-1:0] page_o,
    output pbuf_t             pbuf_o
);

    localparam int PAGE_W = ADDR_W - PAGE_OFS_W;

    logic [PAGE_W-1:0] page_q;
    logic [PAGE_W-1:0] wr_page;
    logic [SLOT_W-1:0] wr_slot;
    logic              byte_ofs_unused;

    logic              slot_valid_q [PAGE_WORDS];
    word_t             slot_data_q  [PAGE_WORDS];

    assign wr_page         = wr_addr_i[ADDR_W-1:PAGE_OFS_W];
    assign wr_slot         = slot_of(wr_addr_i[PAGE_OFS_W-1:0]);
    assign byte_ofs_unused = ^wr_addr_i[BYTE_OFS_W-1:0];
    assign same_page_o     = (wr_page == page_q);
    assign page_o          = page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else if (take_first_i) begin
            page_q <= wr_page;
        end
    end

    for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_slot
        logic hit;
        assign hit = (wr_slot == SLOT_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_valid_q[g] <= 1'b0;
                slot_data_q[g]  <= ERASED_WORD;
            end else if (take_first_i) begin
                slot_valid_q[g] <= hit;
                if (hit) slot_data_q[g] <= wr_data_i;
            end else if (take_more_i && hit) begin
                slot_valid_q[g] <= 1'b1;
                slot_data_q[g]  <= wr_data_i;
            end
        end

        assign pbuf_o.valid[g] = slot_valid_q[g];
        assign pbuf_o.data[g]  = slot_data_q[g];
    end

endmodule

// File: rtl/fpgm_array.sv
module fpgm_array
    import fpgm_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int BLK_ADDR_W  = 8,
    parameter int IMPL_BLOCKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_i,
    input  logic [ADDR_W-PAGE_OFS_W-1:0] page_i,
    input  pbuf_t             pbuf_i,
    input  logic [(1<<(ADDR_W-BLK_ADDR_W))-1:0] lock_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output word_t             rd_data_o
);

    localparam int BLK_IDX_W  = ADDR_W - BLK_ADDR_W;
    localparam int NBLK       = 1 << BLK_IDX_W;
    localparam int PAGE_W     = ADDR_W - PAGE_OFS_W;
    localparam int WADDR_W    = ADDR_W - BYTE_OFS_W;
    localparam int IMPL_WORDS = IMPL_BLOCKS << (BLK_ADDR_W - BYTE_OFS_W);

    function automatic logic [NBLK-1:0] exists_mask();
        logic [NBLK-1:0] m;
        for (int b = 0; b < NBLK; b++) m[b] = (b < IMPL_BLOCKS);
        return m;
    endfunction

    localparam logic [NBLK-1:0] BLK_EXISTS = exists_mask();

    word_t                mem [IMPL_WORDS];
    logic [BLK_IDX_W-1:0] wr_blk, rd_blk;
    logic                 writable;
    logic [WADDR_W-1:0]   rd_word;
    logic                 rd_ofs_unused;

    assign wr_blk        = page_i[PAGE_W-1:PAGE_W-BLK_IDX_W];
    assign writable      = BLK_EXISTS[wr_blk] && !lock_i[wr_blk];
    assign rd_blk        = rd_addr_i[ADDR_W-1:BLK_ADDR_W];
    assign rd_word       = rd_addr_i[ADDR_W-1:BYTE_OFS_W];
    assign rd_ofs_unused = ^rd_addr_i[BYTE_OFS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < IMPL_WORDS; i++) mem[i] <= ERASED_WORD;
        end else if (commit_i && writable) begin
            for (int s = 0; s < PAGE_WORDS; s++) begin
                if (pbuf_i.valid[s]) begin
                    mem[{page_i, SLOT_W'(s)}] <=
                        program_merge(mem[{page_i, SLOT_W'(s)}], pbuf_i.data[s]);
                end
            end
        end
    end

    assign rd_data_o = BLK_EXISTS[rd_blk] ? mem[rd_word] : ERASED_WORD;

endmodule

// File: rtl/fpgm_seq.sv
module fpgm_seq
    import fpgm_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int BLK_ADDR_W  = 8,
    parameter int IMPL_BLOCKS = 3,
    parameter int PGM_CYCLES  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pgm_i,
    input  logic              start_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic [(1<<(ADDR_W-BLK_ADDR_W))-1:0] lock_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [31:0]       rd_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              reject_o
);

    localparam int PAGE_W = ADDR_W - PAGE_OFS_W;

    logic              take_first, take_more, same_page, commit;
    logic [PAGE_W-1:0] page;
    pbuf_t             pbuf;

    fpgm_ctrl #(
        .PGM_CYCLES (PGM_CYCLES)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .pgm_i        (pgm_i),
        .start_i      (start_i),
        .wr_en_i      (wr_en_i),
        .same_page_i  (same_page),
        .take_first_o (take_first),
        .take_more_o  (take_more),
        .commit_o     (commit),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .reject_o     (reject_o)
    );

    fpgm_pagebuf #(
        .ADDR_W (ADDR_W)
    ) u_buf (
        .clk          (clk),
        .rst          (rst),
        .take_first_i (take_first),
        .take_more_i  (take_more),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .same_page_o  (same_page),
        .page_o       (page),
        .pbuf_o       (pbuf)
    );

    fpgm_array #(
        .ADDR_W      (ADDR_W),
        .BLK_ADDR_W  (BLK_ADDR_W),
        .IMPL_BLOCKS (IMPL_BLOCKS)
    ) u_arr (
        .clk       (clk),
        .rst       (rst),
        .commit_i  (commit),
        .page_i    (page),
        .pbuf_i    (pbuf),
        .lock_i    (lock_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/fpgm_seq_chk.sv
module fpgm_seq_chk #(
    parameter int ADDR_W     = 10,
    parameter int PGM_CYCLES = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              pgm_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [31:0]       rd_data_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              reject_o
);

    int   busy_run;
    logic settled;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= 0;
            settled  <= 1'b0;
        end else begin
            busy_run <= busy_o ? busy_run + 1 : 0;
            settled  <= 1'b1;
        end
    end

    // R1: outputs quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && !done_o && !reject_o));

    // R2: a stable read address never sees a bit rise
    a_r2_only_clear: assert property (@(posedge clk) disable iff (rst)
        (settled && $stable(rd_addr_i)) |-> ((rd_data_o & ~$past(rd_data_o)) == 32'h0));

    // R8: busy window length
    a_r8_busy_max: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (busy_run < PGM_CYCLES));
    a_r8_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (busy_run == PGM_CYCLES));
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(busy_o));
    a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R9: writes during the busy window are flagged
    a_r9_busy_reject: assert property (@(posedge clk) disable iff (rst)
        (busy_o && wr_en_i) |=> reject_o);

    // R10: done is held by the enable level
    a_r10_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done_o && pgm_i) |=> done_o);
    a_r10_done_release: assert property (@(posedge clk) disable iff (rst)
        $fell(done_o) |-> !$past(pgm_i));

endmodule

bind fpgm_seq fpgm_seq_chk #(
    .ADDR_W     (ADDR_W),
    .PGM_CYCLES (PGM_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pgm_i     (pgm_i),
    .wr_en_i   (wr_en_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .reject_o  (reject_o)
);

// File: tb/fpgm_seq_test.sv
module fpgm_seq_test;

    localparam int PGM_CYC = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pgm = 1'b0;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  lock = '0;
    logic [9:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        busy_o, done_o, reject_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fpgm_seq uut (
        .clk       (clk),
        .rst       (rst),
        .pgm_i     (pgm),
        .start_i   (start),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .lock_i    (lock),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .reject_o  (reject_o)
    );

    typedef struct packed {
        logic [9:0]  addr;
        logic [31:0] data;
        logic [3:0]  lock;
        logic [31:0] expv;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{10'h004, 32'hFFFF00FF, 4'h0, 32'hFFFF00FF},  // R2 first program
        '{10'h004, 32'h0F0FFFFF, 4'h0, 32'h0F0F00FF},  // R2 AND merge
        '{10'h007, 32'h00FFFFFF, 4'h0, 32'h000F00FF},  // R3 byte bits ignored
        '{10'h11C, 32'h12345678, 4'h2, 32'hFFFFFFFF},  // R6 block 1 locked
        '{10'h11C, 32'h12345678, 4'h0, 32'h12345678},  // R6 unlocked again
        '{10'h2E0, 32'h00000000, 4'h0, 32'h00000000},  // R3 block 2 slot 0
        '{10'h3F8, 32'h00000000, 4'h0, 32'hFFFFFFFF},  // R7 missing block
        '{10'h0F0, 32'hAAAA5555, 4'hD, 32'hFFFFFFFF}   // R6 block 0 locked
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_write(input logic [9:0] a, input logic [31:0] d, output logic rj);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        rj = reject_o;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle_busy(output int cyc);
        cyc = 0;
        while (busy_o && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic release_pgm();
        @(negedge clk); pgm = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        logic        rj;
        logic [31:0] d;
        int          cyc;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", {31'b0, busy_o}, 32'h0);
        check("R1 done", {31'b0, done_o}, 32'h0);
        check("R1 reject", {31'b0, reject_o}, 32'h0);
        rd(10'h000, d); check("R1 word 0x000", d, 32'hFFFFFFFF);
        rd(10'h2FC, d); check("R1 word 0x2FC", d, 32'hFFFFFFFF);

        // Vector table: one word per sequence, readback after release
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pgm = 1'b1; lock = VECS[i].lock;
            do_write(VECS[i].addr, VECS[i].data, rj);
            pulse_start();
            wait_idle_busy(cyc);
            release_pgm();
            lock = 4'h0;
            rd(VECS[i].addr, d);
            check($sformatf("R2/R3/R6/R7 vector %0d", i), d, VECS[i].expv);
        end

        // R8 busy length, no early commit, done with data; R9 write in done; R10 hold
        @(negedge clk); pgm = 1'b1;
        do_write(10'h240, 32'h0000FFFF, rj);
        pulse_start();
        rd(10'h240, d); check("R8 unchanged while busy", d, 32'hFFFFFFFF);
        wait_idle_busy(cyc);
        check("R8 busy cycles", cyc, PGM_CYC);
        check("R8 done at end", {31'b0, done_o}, 32'h1);
        rd(10'h240, d); check("R8 committed", d, 32'h0000FFFF);
        do_write(10'h244, 32'h00000000, rj);
        check("R9 reject in done", {31'b0, rj}, 32'h1);
        repeat (3) @(negedge clk);
        check("R10 done held", {31'b0, done_o}, 32'h1);
        release_pgm();
        check("R10 done released", {31'b0, done_o}, 32'h0);
        rd(10'h244, d); check("R9 done write ignored", d, 32'hFFFFFFFF);

        // R9 write while busy
        @(negedge clk); pgm = 1'b1;
        do_write(10'h248, 32'hFFFF0000, rj);
        pulse_start();
        do_write(10'h24C, 32'h00000000, rj);
        check("R9 reject in busy", {31'b0, rj}, 32'h1);
        wait_idle_busy(cyc);
        release_pgm();
        rd(10'h24C, d); check("R9 busy write ignored", d, 32'hFFFFFFFF);
        rd(10'h248, d); check("R9 staged word kept", d, 32'hFFFF0000);

        // R4 several slots, one rewritten
        @(negedge clk); pgm = 1'b1;
        do_write(10'h040, 32'hA0A0A0A0, rj);
        do_write(10'h04C, 32'h12345678, rj);
        do_write(10'h05C, 32'h0F0F0F0F, rj);
        do_write(10'h04C, 32'hCAFEF00D, rj);
        check("R4 same page accepted", {31'b0, rj}, 32'h0);
        pulse_start();
        wait_idle_busy(cyc);
        release_pgm();
        rd(10'h040, d); check("R4 slot 0", d, 32'hA0A0A0A0);
        rd(10'h04C, d); check("R4 slot 3 last value", d, 32'hCAFEF00D);
        rd(10'h05C, d); check("R4 slot 7", d, 32'h0F0F0F0F);
        rd(10'h044, d); check("R4 unstaged slot 1", d, 32'hFFFFFFFF);

        // R5 other page rejected
        @(negedge clk); pgm = 1'b1;
        do_write(10'h060, 32'h00000000, rj);
        check("R5 first write accepted", {31'b0, rj}, 32'h0);
        do_write(10'h080, 32'h00000000, rj);
        check("R5 other page flagged", {31'b0, rj}, 32'h1);
        pulse_start();
        wait_idle_busy(cyc);
        release_pgm();
        rd(10'h080, d); check("R5 other page untouched", d, 32'hFFFFFFFF);
        rd(10'h060, d); check("R5 latched page programmed", d, 32'h00000000);

        // R10 idle with enable low
        do_write(10'h0A0, 32'h00000000, rj);
        check("R10 idle write no flag", {31'b0, rj}, 32'h0);
        pulse_start();
        check("R10 idle start ignored", {31'b0, busy_o}, 32'h0);
        rd(10'h0A0, d); check("R10 idle write no effect", d, 32'hFFFFFFFF);

        // R11 start and write in the same cycle
        @(negedge clk); pgm = 1'b1;
        do_write(10'h0C0, 32'h00000000, rj);
        @(negedge clk);
        start = 1'b1; wr_en = 1'b1; wr_addr = 10'h0C4; wr_data = 32'h0;
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        check("R11 write flagged", {31'b0, reject_o}, 32'h1);
        check("R11 program started", {31'b0, busy_o}, 32'h1);
        wait_idle_busy(cyc);
        release_pgm();
        rd(10'h0C4, d); check("R11 colliding write dropped", d, 32'hFFFFFFFF);
        rd(10'h0C0, d); check("R11 staged word programmed", d, 32'h00000000);

        // R12 abort during loading
        @(negedge clk); pgm = 1'b1;
        do_write(10'h0E0, 32'h00000000, rj);
        @(negedge clk); pgm = 1'b0;
        @(negedge clk); pgm = 1'b1;
        pulse_start();
        check("R12 start after abort ignored", {31'b0, busy_o}, 32'h0);
        @(negedge clk); pgm = 1'b0;
        @(negedge clk);
        rd(10'h0E0, d); check("R12 staged word discarded", d, 32'hFFFFFFFF);

        summary();
    end

endmodule